// File: doc/BRIEF.md
# FIFO Service-Request Generator for a Synchronous Serial Port

This block decides when the transmit and receive FIFOs of a synchronous serial port need attention. It compares each FIFO's fill level against a programmable trigger level and raises one service flag per direction. The receive flag rises once enough entries have arrived. The transmit flag rises once the FIFO has drained far enough. Each flag drives an unmasked DMA request for its direction. It also drives an interrupt request that passes only when that direction's enable bit is set.

A 32-bit control word is written through a single write strobe and can be read back. The word holds both trigger fields, the two interrupt enables and a loopback select. The loopback select chooses where the receive shifter takes its serial input: from the external receive pin, or internally from the transmit shifter output. The FIFOs, the shifters and the bit clock live outside this block. Every flag and request is registered. Each one reflects the FIFO levels and the control write seen at the previous clock edge.

Top module: `fifo_svc_req`

## Requirements
- R1: While `rst_n` is low, the control word reads as 0 and all six flag and request outputs are 0.
- R2: A write with `ctl_wr_en` high stores bit 0 (receive interrupt enable), bit 1 (transmit interrupt enable), bit 2 (loopback), bits 9:6 (transmit trigger field) and bits 13:10 (receive trigger field). `ctl_rd_data` shows the stored value from the next clock edge.
- R3: Bits 31:14 and 5:3 of a write are ignored and always read back as 0.
- R4: `rx_svc` is 1 when the receive level is at least the receive trigger field plus one, and 0 otherwise.
- R5: `tx_svc` is 1 when the transmit level is at most the transmit trigger field plus one, and 0 otherwise.
- R6: `rx_irq` equals `rx_svc` when the receive interrupt enable is 1, and is 0 otherwise. Clearing the enable does not alter `rx_svc`.
- R7: `tx_irq` equals `tx_svc` when the transmit interrupt enable is 1, and is 0 otherwise. Clearing the enable does not alter `tx_svc`.
- R8: `rx_dma` and `tx_dma` equal their direction's service flag, whatever the interrupt enables hold.
- R9: `rx_shift_in` equals `tx_shift_out` when loopback is 1, and `rxd_pin` when loopback is 0, with no clock delay.
- R10: Flags and requests are registered. At each clock edge they take the levels present at that edge and the control value that edge stores, including a write accepted on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 32 | Control word write value |
| ctl_rd_data | output | 32 | Stored control word; unused bits read 0 |
| rx_level | input | LVL_W (5) | Entries held in the receive FIFO, 0..DEPTH |
| tx_level | input | LVL_W (5) | Entries held in the transmit FIFO, 0..DEPTH |
| rx_svc | output | 1 | Receive service flag |
| tx_svc | output | 1 | Transmit service flag |
| rx_irq | output | 1 | Masked receive interrupt request |
| tx_irq | output | 1 | Masked transmit interrupt request |
| rx_dma | output | 1 | Receive DMA request |
| tx_dma | output | 1 | Transmit DMA request |
| rxd_pin | input | 1 | External serial receive pin |
| tx_shift_out | input | 1 | Serial output of the transmit shifter |
| rx_shift_in | output | 1 | Serial input for the receive shifter |

## Verification
The assertions assume that both level inputs stay within 0..DEPTH. They also assume that the control word and levels are stable around the clock edge, so that the value taken one cycle earlier is the one that produced each flag. The stimulus holds to this: every level sweep runs from 0 to exactly DEPTH, and all inputs change only mid-cycle. The sweeps run under trigger fields of 0, 3, 7 and 15 and under all four enable combinations. They also cover writes that land on the same edge as a level change, and a reset applied mid-run.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int CTL_W      = 32;
  localparam int THR_W      = 4;
  localparam int RX_IE_BIT  = 0;
  localparam int TX_IE_BIT  = 1;
  localparam int LPBK_BIT   = 2;
  localparam int TX_THR_LSB = 6;
  localparam int RX_THR_LSB = TX_THR_LSB + THR_W;
  localparam logic [CTL_W-1:0] CTL_MASK =
    (CTL_W'((1 << (2 * THR_W)) - 1) << TX_THR_LSB) |
    (CTL_W'(1) << LPBK_BIT) | (CTL_W'(1) << TX_IE_BIT) | (CTL_W'(1) << RX_IE_BIT);

  typedef struct packed {
    logic [THR_W-1:0] rx_thr;
    logic [THR_W-1:0] tx_thr;
    logic             lpbk;
    logic             tx_ie;
    logic             rx_ie;
  } ctl_t;

  function automatic ctl_t ctl_unpack(input logic [CTL_W-1:0] w);
    ctl_t c;
    c.rx_ie  = w[RX_IE_BIT];
    c.tx_ie  = w[TX_IE_BIT];
    c.lpbk   = w[LPBK_BIT];
    c.tx_thr = w[TX_THR_LSB +: THR_W];
    c.rx_thr = w[RX_THR_LSB +: THR_W];
    return c;
  endfunction

  function automatic logic [CTL_W-1:0] ctl_pack(input ctl_t c);
    logic [CTL_W-1:0] w;
    w = '0;
    w[RX_IE_BIT]            = c.rx_ie;
    w[TX_IE_BIT]            = c.tx_ie;
    w[LPBK_BIT]             = c.lpbk;
    w[TX_THR_LSB +: THR_W]  = c.tx_thr;
    w[RX_THR_LSB +: THR_W]  = c.rx_thr;
    return w;
  endfunction
endpackage

// File: rtl/fsr_ctl_reg.sv
module fsr_ctl_reg
  import fsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output ctl_t             ctl_q,
  output ctl_t             ctl_nxt,
  output logic [CTL_W-1:0] rd_data
);
  // Next value is exported so downstream flags track a write on the same edge
  always_comb begin
    ctl_nxt = ctl_q;
    if (wr_en) ctl_nxt = ctl_unpack(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_nxt;
  end

  assign rd_data = ctl_pack(ctl_q);
endmodule

// File: rtl/fsr_svc_path.sv
module fsr_svc_path #(
  parameter int LVL_W     = 5,
  parameter int THR_W     = 4,
  parameter bit FILL_SIDE = 1'b1   // 1: request when full enough; 0: when empty enough
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [THR_W-1:0] thr,
  input  logic             ie,
  output logic             svc,
  output logic             irq,
  output logic             dma
);
  localparam int CW = (LVL_W > THR_W ? LVL_W : THR_W) + 1;

  logic [CW-1:0] lvl_x;
  logic [CW-1:0] trig;
  logic          hit;

  assign lvl_x = CW'(level);
  assign trig  = CW'(thr) + CW'(1);

  generate
    if (FILL_SIDE) begin : g_fill
      assign hit = (lvl_x >= trig);
    end else begin : g_drain
      assign hit = (lvl_x <= trig);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc <= 1'b0;
      irq <= 1'b0;
      dma <= 1'b0;
    end else begin
      svc <= hit;
      irq <= hit & ie;
      dma <= hit;
    end
  end
endmodule

// File: rtl/fsr_lpbk_sel.sv
module fsr_lpbk_sel (
  input  logic sel,
  input  logic pin_in,
  input  logic fb_in,
  output logic shift_in
);
  always_comb shift_in = sel ? fb_in : pin_in;
endmodule

// File: rtl/fifo_svc_req.sv
module fifo_svc_req
  import fsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wr_data,
  output logic [CTL_W-1:0] ctl_rd_data,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  output logic             rx_svc,
  output logic             tx_svc,
  output logic             rx_irq,
  output logic             tx_irq,
  output logic             rx_dma,
  output logic             tx_dma,
  input  logic             rxd_pin,
  input  logic             tx_shift_out,
  output logic             rx_shift_in
);
  ctl_t ctl_q;
  ctl_t ctl_nxt;

  fsr_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_wr_en),
    .wr_data (ctl_wr_data),
    .ctl_q   (ctl_q),
    .ctl_nxt (ctl_nxt),
    .rd_data (ctl_rd_data)
  );

  fsr_svc_path #(.LVL_W(LVL_W), .THR_W(THR_W), .FILL_SIDE(1'b1)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .level (rx_level),
    .thr   (ctl_nxt.rx_thr),
    .ie    (ctl_nxt.rx_ie),
    .svc   (rx_svc),
    .irq   (rx_irq),
    .dma   (rx_dma)
  );

  fsr_svc_path #(.LVL_W(LVL_W), .THR_W(THR_W), .FILL_SIDE(1'b0)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .level (tx_level),
    .thr   (ctl_nxt.tx_thr),
    .ie    (ctl_nxt.tx_ie),
    .svc   (tx_svc),
    .irq   (tx_irq),
    .dma   (tx_dma)
  );

  fsr_lpbk_sel u_lpbk (
    .sel      (ctl_q.lpbk),
    .pin_in   (rxd_pin),
    .fb_in    (tx_shift_out),
    .shift_in (rx_shift_in)
  );
endmodule

// File: rtl/fsr_chk.sv
module fsr_chk
  import fsr_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr_en,
  input logic [CTL_W-1:0] ctl_wr_data,
  input logic [CTL_W-1:0] ctl_rd_data,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] tx_level,
  input logic             rx_svc,
  input logic             tx_svc,
  input logic             rx_irq,
  input logic             tx_irq,
  input logic             rx_dma,
  input logic             tx_dma,
  input logic             rxd_pin,
  input logic             tx_shift_out,
  input logic             rx_shift_in
);
  localparam int CW = LVL_W + 1;

  // Set once one edge has passed out of reset, so $past is meaningful
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (ctl_rd_data == '0 && !rx_svc && !tx_svc && !rx_irq && !tx_irq && !rx_dma && !tx_dma));

  assert_write_stores_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en |=> ctl_rd_data == ($past(ctl_wr_data) & CTL_MASK));

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd_data & ~CTL_MASK) == '0);

  assert_rx_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> rx_svc == (CW'($past(rx_level)) > CW'(ctl_rd_data[RX_THR_LSB +: THR_W])));

  assert_tx_trigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> tx_svc == (CW'($past(tx_level)) <= CW'(ctl_rd_data[TX_THR_LSB +: THR_W]) + CW'(1)));

  assert_rx_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq == (rx_svc && ctl_rd_data[RX_IE_BIT]));

  assert_tx_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq == (tx_svc && ctl_rd_data[TX_IE_BIT]));

  assert_dma_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dma == rx_svc) && (tx_dma == tx_svc));

  assert_loopback_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_shift_in == (ctl_rd_data[LPBK_BIT] ? tx_shift_out : rxd_pin));

  assert_write_same_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en && !ctl_wr_data[RX_IE_BIT] |=> !rx_irq);
endmodule

bind fifo_svc_req fsr_chk #(.LVL_W(LVL_W)) u_fsr_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctl_wr_en    (ctl_wr_en),
  .ctl_wr_data  (ctl_wr_data),
  .ctl_rd_data  (ctl_rd_data),
  .rx_level     (rx_level),
  .tx_level     (tx_level),
  .rx_svc       (rx_svc),
  .tx_svc       (tx_svc),
  .rx_irq       (rx_irq),
  .tx_irq       (tx_irq),
  .rx_dma       (rx_dma),
  .tx_dma       (tx_dma),
  .rxd_pin      (rxd_pin),
  .tx_shift_out (tx_shift_out),
  .rx_shift_in  (rx_shift_in)
);

// File: tb/test_fifo_svc_req.sv
`timescale 1ns/1ps
module test_fifo_svc_req;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ctl_wr_en = 1'b0;
  logic [31:0]      ctl_wr_data = '0;
  logic [31:0]      ctl_rd_data;
  logic [LVL_W-1:0] rx_level = '0;
  logic [LVL_W-1:0] tx_level = '0;
  logic             rx_svc, tx_svc, rx_irq, tx_irq, rx_dma, tx_dma;
  logic             rxd_pin = 1'b0;
  logic             tx_shift_out = 1'b0;
  logic             rx_shift_in;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_ctl = '0;
  bit m_rx_svc, m_tx_svc, m_rx_irq, m_tx_irq;

  always #2 clk = ~clk;

  fifo_svc_req #(.DEPTH(DEPTH)) i_fifo_svc_req (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .ctl_rd_data(ctl_rd_data), .rx_level(rx_level), .tx_level(tx_level),
    .rx_svc(rx_svc), .tx_svc(tx_svc), .rx_irq(rx_irq), .tx_irq(tx_irq),
    .rx_dma(rx_dma), .tx_dma(tx_dma), .rxd_pin(rxd_pin),
    .tx_shift_out(tx_shift_out), .rx_shift_in(rx_shift_in)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("R2 R3 control readback", ctl_rd_data, m_ctl);
    check("R4 rx_svc", rx_svc, m_rx_svc);
    check("R5 tx_svc", tx_svc, m_tx_svc);
    check("R6 R10 rx_irq", rx_irq, m_rx_irq);
    check("R7 R10 tx_irq", tx_irq, m_tx_irq);
    check("R8 rx_dma", rx_dma, m_rx_svc);
    check("R8 tx_dma", tx_dma, m_tx_svc);
    check("R9 rx_shift_in", rx_shift_in, m_ctl[2] ? tx_shift_out : rxd_pin);
  endtask

  // One clock: advance the model with the inputs the edge sampled, then compare
  task automatic step();
    int rft, tft;
    @(posedge clk);
    if (!rst_n) begin
      m_ctl = '0;
      m_rx_svc = 0; m_tx_svc = 0; m_rx_irq = 0; m_tx_irq = 0;
    end else begin
      if (ctl_wr_en) begin
        m_ctl = '0;
        m_ctl[0] = ctl_wr_data[0];
        m_ctl[1] = ctl_wr_data[1];
        m_ctl[2] = ctl_wr_data[2];
        m_ctl[9:6] = ctl_wr_data[9:6];
        m_ctl[13:10] = ctl_wr_data[13:10];
      end
      rft = int'(m_ctl[13:10]);
      tft = int'(m_ctl[9:6]);
      m_rx_svc = int'(rx_level) >= rft + 1;
      m_tx_svc = int'(tx_level) <= tft + 1;
      m_rx_irq = m_rx_svc && m_ctl[0];
      m_tx_irq = m_tx_svc && m_ctl[1];
    end
    #1;
    compare();
    if (!rst_n) begin
      check("R1 reset readback", ctl_rd_data, 32'h0);
      check("R1 reset requests", {rx_svc, tx_svc, rx_irq, tx_irq, rx_dma, tx_dma}, 32'h0);
    end
  endtask

  task automatic write(input logic [31:0] w);
    ctl_wr_en = 1'b1;
    ctl_wr_data = w;
    step();
    ctl_wr_en = 1'b0;
    ctl_wr_data = '0;
  endtask

  function automatic logic [31:0] mk(input int rft, input int tft, input bit lp, input bit tie, input bit rie);
    return (32'(rft) << 10) | (32'(tft) << 6) | (32'(lp) << 2) | (32'(tie) << 1) | 32'(rie);
  endfunction

  task automatic sweep();
    for (int l = 0; l <= DEPTH; l++) begin
      rx_level = LVL_W'(l);
      tx_level = LVL_W'(DEPTH - l);
      step();
    end
    for (int l = DEPTH; l >= 0; l--) begin
      rx_level = LVL_W'(l);
      tx_level = LVL_W'(DEPTH - l);
      step();
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) step();
    rst_n = 1'b1;
    step();
    sweep();  // default fields: triggers at 1 entry

    // R4 R5 R6 R7: trigger fields and enable combinations
    for (int t = 0; t < 4; t++) begin
      int thr;
      thr = (t == 0) ? 0 : (t == 1) ? 3 : (t == 2) ? 7 : 15;
      for (int e = 0; e < 4; e++) begin
        rx_level = LVL_W'(thr);
        tx_level = LVL_W'(thr + 2 > DEPTH ? DEPTH : thr + 2);
        write(mk(thr, 15 - thr, 1'b0, e[1], e[0]));  // R10 write with level change
        sweep();
      end
    end

    // R3: reserved bits ignored
    write(32'hFFFF_FFFF);
    step();
    write(32'hFFFF_C038);
    step();

    // R10: enable dropped on the same edge as a level crossing
    write(mk(2, 2, 1'b0, 1'b1, 1'b1));
    rx_level = 5'd3; tx_level = 5'd3;
    step();
    rx_level = 5'd2; tx_level = 5'd4;
    write(mk(2, 2, 1'b0, 1'b0, 1'b0));
    step();

    // R9: loopback select
    for (int lp = 0; lp < 2; lp++) begin
      write(mk(0, 0, lp[0], 1'b0, 1'b0));
      for (int p = 0; p < 8; p++) begin
        rxd_pin = p[0];
        tx_shift_out = p[1];
        #1;
        check("R9 mux immediate", rx_shift_in, lp[0] ? tx_shift_out : rxd_pin);
        step();
      end
    end

    // R1: reset mid-run
    write(mk(5, 5, 1'b1, 1'b1, 1'b1));
    rx_level = 5'd9;
    step();
    rst_n = 1'b0;
    #1;
    check("R1 async reset readback", ctl_rd_data, 32'h0);
    step();
    step();
    rst_n = 1'b1;
    sweep();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule